// File: doc/BRIEF.md
# NAND Flash Host Bus Sequencer

This block sits on the host side of a NAND flash device and turns single bus-cycle requests into strobe sequences on a shared, multiplexed I/O bus. Each request selects a cycle kind (command, address, write data or read data), a chip select, a data value and an 8- or 16-bit bus width. The sequencer drives the chip enable, the latch-enable lines and the write or read strobe with programmable setup, strobe-low and hold lengths. It returns one response per request, carrying the read data or an error flag.

Chip selects use legacy numbering. Select numbers 2, 3, 4 and 5 drive chip-enable outputs 0, 1, 2 and 3. A select may start NAND cycles only when its NAND-mode enable bit is set. Before it asserts any chip enable, the sequencer waits for the device's ready/busy line, which it brings in through two synchronising flops. If the device stays busy past a programmable limit, the request ends with an error.

Top module: `nand_bus_seq`

## Requirements
- R1: A request with `req_cs` equal to 2, 3, 4 or 5 drives exactly `nand_ce_n[0]`, `[1]`, `[2]` or `[3]` low, respectively, for its bus cycle. At most one chip enable is ever low.
- R2: `req_kind` encodes 0 = command, 1 = address, 2 = write data, 3 = read data. `nand_cle` is high only during a command cycle and `nand_ale` only during an address cycle. Both are low in data cycles and in idle, and they are never high together.
- R3: Command, address and write-data cycles pulse `nand_we_n` low. Read cycles pulse `nand_re_n` low. The two strobes are never low together.
- R4: Command and address bytes travel on `nand_io_out[7:0]` with bits 15:8 zero, whatever the width. Write data uses all 16 bits when `req_wide` = 1 and the low 8 bits (upper zero) when `req_wide` = 0. Narrow read data is returned zero-extended.
- R5: `nand_io_oe` is high only while a command, address or write cycle holds a chip enable low, and it is low during reads. Read data is captured from `nand_io_in` at the edge where `nand_re_n` returns high.
- R6: Within one cycle the chip enable is low for max(1,`cfg_t_setup`) clocks before the strobe falls. The strobe then stays low for max(1,`cfg_t_low`) clocks. After it rises, the enable, latch lines and data are held for max(1,`cfg_t_hold`) clocks. A zero setting acts as 1.
- R7: No chip enable is asserted while the synchronised ready/busy input reads busy (`nand_rb_n` = 0). An accepted request waits for the device to become ready.
- R8: If busy persists for `cfg_busy_limit`+1 clocks after acceptance, the request gets an error response and produces no bus activity.
- R9: A request whose `req_cs` is outside 2..5, or whose select has its `cfg_nand_en` bit clear, gets an error response one clock after acceptance and produces no bus activity.
- R10: `req_ready` is high only in idle. Every accepted request yields exactly one single-clock `rsp_valid` pulse, in order. `rsp_data` is zero for non-read requests.
- R11: After reset all chip enables and strobes are high, `nand_cle`, `nand_ale`, `nand_io_oe` and `rsp_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nand_en | input | 4 | NAND-mode enable per chip enable 0..3 |
| cfg_t_setup | input | 4 | Setup clocks before strobe falls (0 acts as 1) |
| cfg_t_low | input | 4 | Strobe low clocks (0 acts as 1) |
| cfg_t_hold | input | 4 | Hold clocks after strobe rises (0 acts as 1) |
| cfg_busy_limit | input | 16 | Busy-wait limit in clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_kind | input | 2 | 0 cmd, 1 addr, 2 write, 3 read |
| req_cs | input | 3 | Legacy chip-select number (2..5 valid) |
| req_data | input | 16 | Command, address byte or write data |
| req_wide | input | 1 | 1 = 16-bit data bus, 0 = 8-bit |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_err | output | 1 | Response is an error |
| rsp_data | output | 16 | Read data (zero otherwise) |
| nand_ce_n | output | 4 | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_io_out | output | 16 | Bus value driven by the host |
| nand_io_oe | output | 1 | Host drives the bus when high |
| nand_io_in | input | 16 | Bus value seen from the device |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
A wrong phase state or counter shows within one bus cycle as a setup, low or hold length that differs from the programmed value. It can also show as a latch line high during the wrong kind of cycle. A wrong chip-select decode asserts the wrong enable, or produces bus activity on a rejected request, before that request's response appears. A broken busy path shows as an enable falling while the device is still busy, or as a timeout error where success was expected. A broken read capture or width mux shows in the response data of the same request.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_WR   = 2'd2,
    K_RD   = 2'd3
  } nbs_kind_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RBWAIT = 3'd1,
    S_SETUP  = 3'd2,
    S_STLO   = 3'd3,
    S_STHI   = 3'd4,
    S_RSP    = 3'd5
  } nbs_state_e;
endpackage

// File: rtl/nbs_rb_sync.sv
module nbs_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  output logic rb_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], rb_async};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rb_sync = sh_q[STAGES-1];
endmodule

// File: rtl/nbs_cs_map.sv
module nbs_cs_map #(
  parameter int CS_N    = 4,
  parameter int CS_BASE = 2,
  parameter int CSW     = 3
) (
  input  logic [CSW-1:0]  cs_num,
  input  logic [CS_N-1:0] nand_en,
  output logic [CS_N-1:0] sel,
  output logic            hit
);
  for (genvar i = 0; i < CS_N; i++) begin : g_sel
    localparam logic [CSW-1:0] NUM = CSW'(CS_BASE + i);
    assign sel[i] = (cs_num == NUM) && nand_en[i];
  end
  assign hit = |sel;
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nbs_pkg::*;
#(
  parameter int CS_N = 4,
  parameter int DW   = 16,
  parameter int TW   = 4,
  parameter int LIMW = 16,
  parameter int CSW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CS_N-1:0] cfg_nand_en,
  input  logic [TW-1:0]   cfg_t_setup,
  input  logic [TW-1:0]   cfg_t_low,
  input  logic [TW-1:0]   cfg_t_hold,
  input  logic [LIMW-1:0] cfg_busy_limit,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_kind,
  input  logic [CSW-1:0]  req_cs,
  input  logic [DW-1:0]   req_data,
  input  logic            req_wide,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [DW-1:0]   rsp_data,
  output logic [CS_N-1:0] nand_ce_n,
  output logic            nand_cle,
  output logic            nand_ale,
  output logic            nand_we_n,
  output logic            nand_re_n,
  output logic [DW-1:0]   nand_io_out,
  output logic            nand_io_oe,
  input  logic [DW-1:0]   nand_io_in,
  input  logic            nand_rb_n
);
  localparam int LW = DW / 2;

  nbs_state_e      state_q, state_d;
  logic [LIMW-1:0] cnt_q, cnt_d;
  nbs_kind_e       kind_q, kind_d;
  logic [CS_N-1:0] ce_q, ce_d;
  logic [DW-1:0]   data_q, data_d;
  logic            wide_q, wide_d;
  logic            err_q, err_d;
  logic [DW-1:0]   rdat_q, rdat_d;
  logic [CS_N-1:0] cs_sel;
  logic            cs_hit;
  logic            rb_s;
  logic            active, is_rd;
  logic            accept;

  function automatic logic [LIMW-1:0] phase_len(input logic [TW-1:0] v);
    logic [TW-1:0] e;
    e = (v == '0) ? TW'(1) : v;
    return LIMW'(e - TW'(1));
  endfunction

  nbs_rb_sync #(.STAGES(2)) u_rb_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rb_async (nand_rb_n),
    .rb_sync  (rb_s)
  );

  nbs_cs_map #(.CS_N(CS_N), .CS_BASE(2), .CSW(CSW)) u_cs_map (
    .cs_num  (req_cs),
    .nand_en (cfg_nand_en),
    .sel     (cs_sel),
    .hit     (cs_hit)
  );

  assign accept = req_valid && (state_q == S_IDLE);

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    kind_d  = kind_q;
    ce_d    = ce_q;
    data_d  = data_q;
    wide_d  = wide_q;
    err_d   = err_q;
    rdat_d  = rdat_q;
    unique case (state_q)
      S_IDLE: if (accept) begin
        kind_d = nbs_kind_e'(req_kind);
        ce_d   = cs_sel;
        data_d = req_data;
        wide_d = req_wide;
        rdat_d = '0;
        cnt_d  = '0;
        err_d  = !cs_hit;
        state_d = cs_hit ? S_RBWAIT : S_RSP;
      end
      S_RBWAIT: begin
        if (rb_s) begin
          cnt_d   = phase_len(cfg_t_setup);
          state_d = S_SETUP;
        end else if (cnt_q == cfg_busy_limit) begin
          err_d   = 1'b1;
          state_d = S_RSP;
        end else begin
          cnt_d = cnt_q + LIMW'(1);
        end
      end
      S_SETUP: begin
        if (cnt_q == '0) begin
          cnt_d   = phase_len(cfg_t_low);
          state_d = S_STLO;
        end else cnt_d = cnt_q - LIMW'(1);
      end
      S_STLO: begin
        if (cnt_q == '0) begin
          cnt_d   = phase_len(cfg_t_hold);
          state_d = S_STHI;
          if (kind_q == K_RD)
            rdat_d = wide_q ? nand_io_in : {{(DW-LW){1'b0}}, nand_io_in[LW-1:0]};
        end else cnt_d = cnt_q - LIMW'(1);
      end
      S_STHI: begin
        if (cnt_q == '0) state_d = S_RSP;
        else             cnt_d = cnt_q - LIMW'(1);
      end
      S_RSP:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      kind_q  <= K_CMD;
      ce_q    <= '0;
      data_q  <= '0;
      wide_q  <= 1'b0;
      err_q   <= 1'b0;
      rdat_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
      ce_q    <= ce_d;
      data_q  <= data_d;
      wide_q  <= wide_d;
      err_q   <= err_d;
      rdat_q  <= rdat_d;
    end
  end

  // bus decode from registered state
  assign active    = (state_q == S_SETUP) || (state_q == S_STLO) || (state_q == S_STHI);
  assign is_rd     = (kind_q == K_RD);
  assign nand_ce_n = active ? ~ce_q : '1;
  assign nand_cle  = active && (kind_q == K_CMD);
  assign nand_ale  = active && (kind_q == K_ADDR);
  assign nand_we_n = !((state_q == S_STLO) && !is_rd);
  assign nand_re_n = !((state_q == S_STLO) && is_rd);
  assign nand_io_oe = active && !is_rd;

  always_comb begin
    nand_io_out = '0;
    if (active && !is_rd) begin
      if (kind_q == K_WR && wide_q) nand_io_out = data_q;
      else                          nand_io_out = {{(DW-LW){1'b0}}, data_q[LW-1:0]};
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign rsp_valid = (state_q == S_RSP);
  assign rsp_err   = err_q;
  assign rsp_data  = rdat_q;
endmodule

// File: rtl/nbs_chk.sv
module nbs_chk #(
  parameter int CS_N = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CS_N-1:0] ce_n,
  input logic            cle,
  input logic            ale,
  input logic            we_n,
  input logic            re_n,
  input logic            io_oe,
  input logic            rb_s,
  input logic            rsp_valid
);
  a_r1_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ce_n) <= 1);
  a_r2_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  a_r5_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !io_oe);
  a_r6_hold_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n) || $rose(re_n)) |-> !(&ce_n));
  a_r7_ready_before_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&ce_n) |-> $past(rb_s));
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind nand_bus_seq nbs_chk #(.CS_N(CS_N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (nand_ce_n),
  .cle       (nand_cle),
  .ale       (nand_ale),
  .we_n      (nand_we_n),
  .re_n      (nand_re_n),
  .io_oe     (nand_io_oe),
  .rb_s      (rb_s),
  .rsp_valid (rsp_valid)
);

// File: tb/nand_bus_seq_tb.sv
module nand_bus_seq_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          kind;
    logic [3:0]  ce_n;
    logic [15:0] io;
    int          su, lo, hi;
  } bus_item_t;

  typedef struct {
    logic        err;
    logic [15:0] data;
  } rsp_item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cfg_nand_en;
  logic [3:0]  cfg_t_setup, cfg_t_low, cfg_t_hold;
  logic [15:0] cfg_busy_limit;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic [2:0]  req_cs;
  logic [15:0] req_data;
  logic        req_wide;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_data;
  logic [3:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [15:0] nand_io_out, nand_io_in;
  logic        nand_rb_n;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  bus_item_t exp_bus[$];
  rsp_item_t exp_rsp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bus_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_nand_en(cfg_nand_en), .cfg_t_setup(cfg_t_setup), .cfg_t_low(cfg_t_low),
    .cfg_t_hold(cfg_t_hold), .cfg_busy_limit(cfg_busy_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_cs(req_cs), .req_data(req_data), .req_wide(req_wide),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [3:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  // bus monitor: one window per chip-enable assertion
  logic        in_win = 1'b0, seen;
  int          su, lo, hi;
  logic [3:0]  w_ce;
  logic        w_we, w_cle, w_ale, w_oe, w_rb;
  logic [15:0] w_io;

  always @(negedge clk) begin
    if (rst_n) begin
      if (nand_ce_n != 4'hF) begin
        if (!in_win) begin
          in_win = 1'b1; seen = 1'b0; su = 0; lo = 0; hi = 0;
          w_ce = nand_ce_n; w_rb = nand_rb_n;
        end
        if (!nand_we_n || !nand_re_n) begin
          lo++; seen = 1'b1;
          w_we = !nand_we_n; w_cle = nand_cle; w_ale = nand_ale;
          w_oe = nand_io_oe; w_io = nand_io_out;
        end else if (seen) hi++;
        else su++;
      end else if (in_win) begin
        in_win = 1'b0;
        if (exp_bus.size() == 0) begin
          check("R9 unexpected bus activity", 32'(w_ce), 32'hF);
        end else begin
          bus_item_t e;
          e = exp_bus.pop_front();
          check("R1 chip enable", 32'(w_ce), 32'(e.ce_n));
          check("R7 ready when enabled", 32'(w_rb), 32'd1);
          check("R3 strobe kind", 32'(w_we), 32'(e.kind != 3));
          check("R2 cle level", 32'(w_cle), 32'(e.kind == 0));
          check("R2 ale level", 32'(w_ale), 32'(e.kind == 1));
          check("R5 output enable", 32'(w_oe), 32'(e.kind != 3));
          if (e.kind != 3) check("R4 bus value", 32'(w_io), 32'(e.io));
          check("R6 setup clocks", 32'(su), 32'(e.su));
          check("R6 low clocks", 32'(lo), 32'(e.lo));
          check("R6 hold clocks", 32'(hi), 32'(e.hi));
        end
      end
      if (rsp_valid) begin
        if (exp_rsp.size() == 0) begin
          check("R10 unexpected response", 32'd1, 32'd0);
        end else begin
          rsp_item_t r;
          r = exp_rsp.pop_front();
          check("R10 response error flag", 32'(rsp_err), 32'(r.err));
          check("R5 response data", 32'(rsp_data), 32'(r.data));
        end
      end
    end
  end

  // driver: pushes expectations, then issues the request
  task automatic send(input int kind, input int cs, input logic [15:0] d,
                      input logic wide, input logic [15:0] rd_val, input logic bad);
    bus_item_t b;
    rsp_item_t r;
    r.err = bad;
    r.data = (!bad && kind == 3) ? (wide ? rd_val : {8'h00, rd_val[7:0]}) : 16'h0;
    if (!bad) begin
      b.kind = kind;
      b.ce_n = ~(4'b0001 << (cs - 2));
      b.io   = (kind == 2 && wide) ? d : {8'h00, d[7:0]};
      b.su   = eff(cfg_t_setup);
      b.lo   = eff(cfg_t_low);
      b.hi   = eff(cfg_t_hold);
      exp_bus.push_back(b);
    end
    exp_rsp.push_back(r);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    nand_io_in = rd_val;
    req_kind = 2'(kind); req_cs = 3'(cs); req_data = d; req_wide = wide;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_rsp.size() != 0 || exp_bus.size() != 0) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 0; req_cs = 0; req_data = 0; req_wide = 0;
    cfg_nand_en = 4'b1111; cfg_t_setup = 1; cfg_t_low = 1; cfg_t_hold = 1;
    cfg_busy_limit = 16'd100; nand_io_in = 0; nand_rb_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 ce_n", 32'(nand_ce_n), 32'hF);
    check("R11 strobes", 32'({nand_we_n, nand_re_n}), 32'h3);
    check("R11 latch and oe", 32'({nand_cle, nand_ale, nand_io_oe}), 32'h0);
    check("R11 rsp_valid", 32'(rsp_valid), 32'h0);
    check("R11 req_ready", 32'(req_ready), 32'h1);

    // R1 R2 R3 R4 minimal timing on every select
    send(0, 2, 16'h1290, 1'b1, 16'h0, 1'b0);
    send(1, 3, 16'h5A3C, 1'b1, 16'h0, 1'b0);
    send(2, 4, 16'hABCD, 1'b0, 16'h0, 1'b0);
    send(2, 5, 16'hABCD, 1'b1, 16'h0, 1'b0);
    send(3, 3, 16'h0, 1'b0, 16'hBEEF, 1'b0);
    send(3, 5, 16'h0, 1'b1, 16'hC0DE, 1'b0);

    // R6 longer phases, and zero settings acting as one
    cfg_t_setup = 3; cfg_t_low = 2; cfg_t_hold = 4;
    send(0, 4, 16'h0070, 1'b0, 16'h0, 1'b0);
    send(3, 2, 16'h0, 1'b1, 16'h1234, 1'b0);
    cfg_t_setup = 0; cfg_t_low = 0; cfg_t_hold = 0;
    send(2, 3, 16'h8001, 1'b1, 16'h0, 1'b0);

    // R9 disabled select and out-of-range numbers
    cfg_nand_en = 4'b1011;
    send(0, 4, 16'h00FF, 1'b0, 16'h0, 1'b1);
    send(0, 5, 16'h0011, 1'b0, 16'h0, 1'b0);
    cfg_nand_en = 4'b1111;
    send(0, 1, 16'h0011, 1'b0, 16'h0, 1'b1);
    send(0, 7, 16'h0011, 1'b0, 16'h0, 1'b1);

    // R8 busy timeout
    cfg_busy_limit = 16'd20;
    nand_rb_n = 1'b0;
    send(1, 2, 16'h0042, 1'b0, 16'h0, 1'b1);

    // R7 wait for ready, then proceed
    cfg_busy_limit = 16'd1000;
    fork
      send(0, 3, 16'h0010, 1'b0, 16'h0, 1'b0);
      begin
        repeat (30) @(negedge clk);
        check("R7 no enable while busy", 32'(nand_ce_n), 32'hF);
        nand_rb_n = 1'b1;
      end
    join

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule